// File: doc/BRIEF.md
# Capability Seal and Unseal Unit

This unit turns a capability into an opaque, tamper-evident token (seal) or turns such a token back into a usable capability (unseal). Each request carries a source capability (validity tag, permission bits, address, 3-bit object type) and an authorising capability (tag, permission bits, address value). Sealing stamps the authoriser's value into the source's object type. Unsealing succeeds only when the authoriser's value equals that object type. An object type of zero means the capability is unsealed.

No operation ever traps. Every rejected request returns the source fields unchanged with the tag cleared, together with a status code that names the reason. The execute permission of the source picks the name space of object types. For executable sources the values 1 to 3 belong to hardware-managed entry kinds, so software can neither seal to them nor unseal them here. One request is accepted per cycle, and each result appears after a fixed pipeline latency `LAT`.

Top module: `cap_seal_unit`

## Requirements
- R1: After reset, and until a request has been accepted, `rsp_valid` is 0.
- R2: A request taken with `req_valid`=1 on a rising edge produces exactly one result with `rsp_valid`=1 exactly `LAT` rising edges later (default 2). `rsp_valid` is 0 in the cycles between.
- R3: A seal (`req_op`=0) succeeds when both tags are 1, the authoriser holds the seal permission (bit 4), the source object type is 0, and the authoriser value is in 1..7. The result then has tag 1, object type equal to the authoriser value, status 0, and the source permissions and address unchanged.
- R4: For an executable source (permission bit 3 set), sealing with a value in 1..3 is rejected with status 3. Values 4..7 succeed.
- R5: An unseal (`req_op`=1) succeeds when both tags are 1, the authoriser holds the unseal permission (bit 5), the source is sealed, and the authoriser value equals the source object type. The result has tag 1, object type 0, status 0, and permissions and address unchanged.
- R6: An unseal whose authoriser value differs from the source object type returns status 5 with tag 0. Object type, permissions and address are returned as given.
- R7: If either input tag is 0, the result is untagged with status 1. This check has the highest priority.
- R8: If the permission needed by the operation (seal bit 4 or unseal bit 5) is missing from the authoriser, the result is untagged with status 2.
- R9: Sealing an already sealed source, or unsealing an unsealed source, gives an untagged result with status 4.
- R10: A seal whose authoriser value is 0 or greater than 7 gives an untagged result with status 3.
- R11: Unsealing an executable source whose object type is in 1..3 gives an untagged result with status 3.
- R12: The checks apply in this priority order: tag (1), permission (2), seal state (4), value range or reserved kind (3), type mismatch (5). Every failed result carries the source object type, permissions and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 = seal, 1 = unseal |
| src_tag | input | 1 | Source validity tag |
| src_perms | input | PW | Source permission bits |
| src_addr | input | AW | Source address |
| src_otype | input | 3 | Source object type |
| auth_tag | input | 1 | Authoriser validity tag |
| auth_perms | input | PW | Authoriser permission bits |
| auth_addr | input | AW | Authoriser value |
| rsp_valid | output | 1 | Result strobe |
| rsp_tag | output | 1 | Result tag |
| rsp_otype | output | 3 | Result object type |
| rsp_perms | output | PW | Result permissions |
| rsp_addr | output | AW | Result address |
| rsp_status | output | 3 | 0 ok, 1 untagged input, 2 no permission, 3 bad/reserved value, 4 wrong seal state, 5 mismatch |

## Verification
Seals are tried with data and executable sources across the value boundaries 0, 1, 3, 4, 7 and 8, which separates the range check from the reserved-kind check. Unseals are tried with matching and non-matching values, with unsealed sources, and with executable sources carrying reserved kinds, which keeps the mismatch status apart from the state and reserved statuses. Requests with several faults at once confirm the priority order. Each result is also checked for an unchanged address and permissions and for arrival on the exact latency cycle.

// File: rtl/cap_seal_unit.sv
module cap_seal_unit #(
  parameter int AW  = 32,
  parameter int PW  = 8,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic          src_tag,
  input  logic [PW-1:0] src_perms,
  input  logic [AW-1:0] src_addr,
  input  logic [2:0]    src_otype,
  input  logic          auth_tag,
  input  logic [PW-1:0] auth_perms,
  input  logic [AW-1:0] auth_addr,
  output logic          rsp_valid,
  output logic          rsp_tag,
  output logic [2:0]    rsp_otype,
  output logic [PW-1:0] rsp_perms,
  output logic [AW-1:0] rsp_addr,
  output logic [2:0]    rsp_status
);
  localparam int OTW = 3;
  localparam int RW = 1 + OTW + PW + AW + 3;
  localparam int P_EXEC = 3;
  localparam int P_SEAL = 4;
  localparam int P_UNSEAL = 5;
  localparam logic [OTW-1:0] KIND_MAX = 3'd3;
  localparam logic [2:0] ST_OK = 3'd0, ST_TAG = 3'd1, ST_PERM = 3'd2,
                         ST_VALUE = 3'd3, ST_STATE = 3'd4, ST_MISMATCH = 3'd5;

  logic [OTW-1:0] auth_ot;
  logic is_exec, is_sealed, auth_in_range, seal_reserved, unseal_reserved;
  logic [2:0] status_d;
  logic [RW-1:0] res_d;

  assign auth_ot = auth_addr[OTW-1:0];
  assign is_exec = src_perms[P_EXEC];
  assign is_sealed = src_otype != '0;
  assign auth_in_range = (auth_addr >> OTW) == '0 && auth_ot != '0;
  assign seal_reserved = is_exec && auth_ot <= KIND_MAX;
  assign unseal_reserved = is_exec && src_otype <= KIND_MAX;

  always_comb begin
    if (!src_tag || !auth_tag)
      status_d = ST_TAG;
    else if (req_op ? !auth_perms[P_UNSEAL] : !auth_perms[P_SEAL])
      status_d = ST_PERM;
    else if (req_op ? !is_sealed : is_sealed)
      status_d = ST_STATE;
    else if (req_op ? unseal_reserved : (!auth_in_range || seal_reserved))
      status_d = ST_VALUE;
    else if (req_op && auth_addr != AW'(src_otype))
      status_d = ST_MISMATCH;
    else
      status_d = ST_OK;
  end

  always_comb begin
    if (status_d == ST_OK)
      res_d = {1'b1, (req_op ? {OTW{1'b0}} : auth_ot), src_perms, src_addr, status_d};
    else
      res_d = {1'b0, src_otype, src_perms, src_addr, status_d};
  end

  logic [LAT-1:0] vld_q;
  logic [RW-1:0]  res_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) res_q[i] <= '0;
    end else begin
      vld_q[0] <= req_valid;
      res_q[0] <= res_d;
      for (int i = 1; i < LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        res_q[i] <= res_q[i-1];
      end
    end
  end

  assign rsp_valid = vld_q[LAT-1];
  assign {rsp_tag, rsp_otype, rsp_perms, rsp_addr, rsp_status} = res_q[LAT-1];
endmodule

// File: rtl/cap_seal_unit_chk.sv
module cap_seal_unit_chk #(
  parameter int PW  = 8,
  parameter int LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_op,
  input logic [PW-1:0] src_perms,
  input logic          rsp_valid,
  input logic          rsp_tag,
  input logic [2:0]    rsp_otype,
  input logic [2:0]    rsp_status
);
  logic [LAT-1:0] v_sh, op_sh, x_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_sh <= '0; op_sh <= '0; x_sh <= '0;
    end else begin
      v_sh[0] <= req_valid; op_sh[0] <= req_op; x_sh[0] <= src_perms[3];
      for (int i = 1; i < LAT; i++) begin
        v_sh[i] <= v_sh[i-1]; op_sh[i] <= op_sh[i-1]; x_sh[i] <= x_sh[i-1];
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == v_sh[LAT-1]);
  p_fail_untagged_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 3'd0 |-> !rsp_tag);
  p_ok_tagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 |-> rsp_tag);
  p_seal_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 && !op_sh[LAT-1] |-> rsp_otype != 3'd0);
  p_exec_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 && !op_sh[LAT-1] && x_sh[LAT-1] |-> rsp_otype > 3'd3);
  p_unseal_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 3'd0 && op_sh[LAT-1] |-> rsp_otype == 3'd0);
  p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status <= 3'd5);
endmodule

bind cap_seal_unit cap_seal_unit_chk #(.PW(PW), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .src_perms(src_perms), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .rsp_otype(rsp_otype), .rsp_status(rsp_status));

// File: tb/cap_seal_unit_tb_top.sv
module cap_seal_unit_tb_top;
  localparam int AW = 32, PW = 8;
  localparam logic [7:0] PX = 8'h08, PS = 8'h10, PU = 8'h20, PRW = 8'h06;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0, src_tag = 0, auth_tag = 0;
  logic [PW-1:0] src_perms = '0, auth_perms = '0;
  logic [AW-1:0] src_addr = '0, auth_addr = '0;
  logic [2:0] src_otype = '0;
  logic rsp_valid, rsp_tag;
  logic [2:0] rsp_otype, rsp_status;
  logic [PW-1:0] rsp_perms;
  logic [AW-1:0] rsp_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_seal_unit #(.AW(AW), .PW(PW), .LAT(2)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic op, input logic stag,
                        input logic [7:0] sperm, input logic [31:0] saddr, input logic [2:0] sot,
                        input logic atag, input logic [7:0] aperm, input logic [31:0] aaddr,
                        input logic etag, input logic [2:0] eot, input logic [2:0] est);
    @(negedge clk);
    req_valid = 1; req_op = op; src_tag = stag; src_perms = sperm; src_addr = saddr;
    src_otype = sot; auth_tag = atag; auth_perms = aperm; auth_addr = aaddr;
    @(negedge clk);
    req_valid = 0; src_tag = 0; auth_tag = 0; src_addr = '0; src_perms = '0;
    check(rsp_valid == 0, "R2 early", $sformatf("valid=%0d", rsp_valid), "valid=0");
    @(negedge clk);
    check(rsp_valid == 1 && rsp_tag == etag && rsp_otype == eot && rsp_status == est
          && rsp_perms == sperm && rsp_addr == saddr, req,
          $sformatf("v=%0d tag=%0d ot=%0d st=%0d p=%h a=%h", rsp_valid, rsp_tag, rsp_otype,
                    rsp_status, rsp_perms, rsp_addr),
          $sformatf("v=1 tag=%0d ot=%0d st=%0d p=%h a=%h", etag, eot, est, sperm, saddr));
    @(negedge clk);
    check(rsp_valid == 0, "R2 single", $sformatf("valid=%0d", rsp_valid), "valid=0");
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R1", $sformatf("valid=%0d", rsp_valid), "valid=0");
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R1 idle", $sformatf("valid=%0d", rsp_valid), "valid=0");
  endtask

  task automatic t_seal_data;
    run_op("R3 seal 5", 0, 1, PRW, 32'h1000, 0, 1, PS, 5, 1, 5, 0);
    run_op("R3 seal 1", 0, 1, PRW, 32'h2004, 0, 1, PS, 1, 1, 1, 0);
    run_op("R3 seal 7", 0, 1, PRW, 32'hFFFF_FFF0, 0, 1, PS, 7, 1, 7, 0);
  endtask

  task automatic t_seal_exec;
    run_op("R4 exec 2", 0, 1, PX, 32'h400, 0, 1, PS, 2, 0, 0, 3);
    run_op("R4 exec 3", 0, 1, PX, 32'h404, 0, 1, PS, 3, 0, 0, 3);
    run_op("R4 exec 4", 0, 1, PX, 32'h408, 0, 1, PS, 4, 1, 4, 0);
  endtask

  task automatic t_unseal;
    run_op("R5 unseal data", 1, 1, PRW, 32'h3000, 6, 1, PU, 6, 1, 0, 0);
    run_op("R5 unseal exec", 1, 1, PX, 32'h500, 4, 1, PU, 4, 1, 0, 0);
    run_op("R6 mismatch", 1, 1, PRW, 32'h3000, 6, 1, PU, 5, 0, 6, 5);
    run_op("R6 high bits", 1, 1, PRW, 32'h3000, 6, 1, PU, 32'h106, 0, 6, 5);
  endtask

  task automatic t_faults;
    run_op("R7 src untagged", 0, 0, PRW, 32'h10, 0, 1, PS, 5, 0, 0, 1);
    run_op("R7 auth untagged", 1, 1, PRW, 32'h10, 3, 0, 8'h00, 9, 0, 3, 1);
    run_op("R8 no seal perm", 0, 1, PRW, 32'h20, 0, 1, PU, 5, 0, 0, 2);
    run_op("R8 no unseal perm", 1, 1, PRW, 32'h20, 5, 1, PS, 5, 0, 5, 2);
    run_op("R9 reseal", 0, 1, PRW, 32'h30, 2, 1, PS, 5, 0, 2, 4);
    run_op("R9 unseal plain", 1, 1, PRW, 32'h30, 0, 1, PU, 0, 0, 0, 4);
    run_op("R10 value 0", 0, 1, PRW, 32'h40, 0, 1, PS, 0, 0, 0, 3);
    run_op("R10 value 8", 0, 1, PRW, 32'h40, 0, 1, PS, 8, 0, 0, 3);
    run_op("R11 kind unseal", 1, 1, PX, 32'h50, 2, 1, PU, 2, 0, 2, 3);
  endtask

  task automatic t_priority;
    run_op("R12 tag over perm", 0, 0, PRW, 32'h60, 3, 1, 8'h00, 9, 0, 3, 1);
    run_op("R12 perm over state", 0, 1, PRW, 32'h60, 3, 1, PU, 9, 0, 3, 2);
    run_op("R12 state over value", 0, 1, PX, 32'h60, 3, 1, PS, 9, 0, 3, 4);
    run_op("R12 value over mismatch", 1, 1, PX, 32'h60, 1, 1, PU, 6, 0, 1, 3);
  endtask

  initial begin
    t_reset();
    t_seal_data();
    t_seal_exec();
    t_unseal();
    t_faults();
    t_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2 actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule